// File: doc/BRIEF.md
# Prescaled Up-Counting Update Timer

This block is a general-purpose interval timer for a peripheral subsystem. A clock-enable divider slows the system clock by a programmable ratio, and a 16-bit counter steps on each divided tick from zero up to a programmable limit. When the counter passes that limit it wraps to zero. The wrap produces a one-clock update pulse, and it can latch a status flag that drives a level interrupt request.

The divide ratio and the wrap limit are double-buffered. Software writes go to a holding register. The running logic keeps the working copy until the next update, so a new setting never corrupts a period already in progress. Software can force an update at any time. A forced update loads both working copies, clears both internal counters and emits the update pulse. A control bit can make forced updates leave the status flag alone. A second control bit stops the timer after one wrap. The status flag is cleared by writing zero to its bit and is kept when that bit is written with one.

Registers are reached through a plain synchronous write strobe and a combinational read mux. Both are selected by a 3-bit address.

Top module: `basic_update_timer`

## Requirements
- R1: After reset, every register reads 0 except RELOAD (address 2), which reads 0xFFFF, and `irq_o` is low. The register addresses are: CTRL 0, DIV 1, RELOAD 2, FORCE 3, IEN 4, STAT 5, COUNT 6. CTRL holds bit0 run, bit1 single-shot and bit2 wrap-only. IEN bit0 and STAT bit0 hold the interrupt enable and the update flag.
- R2: While run is set, `upd_o` pulses for one clock every (D+1)*(L+1) clocks. D and L are the working divide and limit values. The first pulse comes (D+1)*(L+1) cycles after the cycle in which the run bit is written.
- R3: A write to DIV or RELOAD does not change the running period until the next update event. The update that ends the current period loads the new value.
- R4: Writing 1 to FORCE bit0 raises `upd_o` in that same cycle, loads both working copies and clears the counter and the divider. FORCE always reads 0.
- R5: With wrap-only set, a forced update leaves the status flag unchanged.
- R6: With wrap-only clear, both a forced update and a wrap set the status flag.
- R7: With single-shot set, a wrap clears the run bit, and the single-shot bit stays set.
- R8: Writing STAT with bit0 = 0 clears the flag. Writing it with bit0 = 1 leaves the flag unchanged.
- R9: A wrap in the same cycle as a clearing write to STAT leaves the flag set.
- R10: `irq_o` is high exactly while the flag and the interrupt enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register (combinational) |
| upd_o | output | 1 | One-clock update event pulse |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions take for granted that at most one register is written per cycle and that `addr` stays within the seven decoded values. As a result, a forced update can never share a cycle with a STAT or CTRL write. The stimulus changes inputs only between clock edges and issues one write per cycle. It only ever addresses the decoded registers, and it starts each run from a forced update, so the working copies are known before any period is timed.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_DIV    = 3'd1,
        REG_RELOAD = 3'd2,
        REG_FORCE  = 3'd3,
        REG_IEN    = 3'd4,
        REG_STAT   = 3'd5,
        REG_COUNT  = 3'd6
    } reg_sel_e;

    localparam int CTRL_RUN     = 0;
    localparam int CTRL_ONESHOT = 1;
    localparam int CTRL_WRAPONL = 2;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         force_upd,
    input  logic         upd,
    input  logic [W-1:0] div_pre,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] div_sh;
        logic [W-1:0] cnt;
    } st_t;

    st_t st_q, st_d;

    assign tick = run && (st_q.cnt == st_q.div_sh);

    always_comb begin
        st_d = st_q;
        if (run) begin
            st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        end
        if (force_upd) begin
            st_d.cnt = '0;
        end
        if (upd) begin
            st_d.div_sh = div_pre;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Working divide value changes only on an update
    assert_div_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(st_q.div_sh));

    // Divider restarts after every tick
    assert_div_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (st_q.cnt == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         force_upd,
    input  logic         upd,
    input  logic [W-1:0] limit_pre,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] lim_sh;
        logic [W-1:0] cnt;
    } st_t;

    st_t st_q, st_d;

    assign cnt = st_q.cnt;
    assign ovf = tick && (st_q.cnt == st_q.lim_sh);

    always_comb begin
        st_d = st_q;
        if (tick) begin
            st_d.cnt = ovf ? '0 : st_q.cnt + 1'b1;
        end
        if (force_upd) begin
            st_d.cnt = '0;
        end
        if (upd) begin
            st_d.lim_sh = limit_pre;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{lim_sh: '1, cnt: '0};
        else        st_q <= st_d;
    end

    // A forced update leaves the counter at zero
    assert_force_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        force_upd |=> (st_q.cnt == '0));

    // Working limit changes only on an update
    assert_limit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(st_q.lim_sh));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wdata,
    input  logic              ovf,
    input  logic [W-1:0]      cnt,
    output logic              run,
    output logic              force_upd,
    output logic [W-1:0]      div_pre,
    output logic [W-1:0]      limit_pre,
    output logic              flag,
    output logic              ien,
    output logic [W-1:0]      rdata
);
    typedef struct packed {
        logic         run;
        logic         oneshot;
        logic         wraponly;
        logic         ien;
        logic         flag;
        logic [W-1:0] div;
        logic [W-1:0] lim;
    } st_t;

    st_t st_q, st_d;
    reg_sel_e sel;

    assign sel       = reg_sel_e'(addr);
    assign force_upd = wr_en && (sel == REG_FORCE) && wdata[0];
    assign run       = st_q.run;
    assign div_pre   = st_q.div;
    assign limit_pre = st_q.lim;
    assign flag      = st_q.flag;
    assign ien       = st_q.ien;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                REG_CTRL: begin
                    st_d.run      = wdata[CTRL_RUN];
                    st_d.oneshot  = wdata[CTRL_ONESHOT];
                    st_d.wraponly = wdata[CTRL_WRAPONL];
                end
                REG_DIV:    st_d.div = wdata;
                REG_RELOAD: st_d.lim = wdata;
                REG_IEN:    st_d.ien = wdata[0];
                REG_STAT:   if (!wdata[0]) st_d.flag = 1'b0;
                default:    ;
            endcase
        end
        if (ovf && st_q.oneshot) begin
            st_d.run = 1'b0;
        end
        if (ovf || (force_upd && !st_q.wraponly)) begin
            st_d.flag = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            REG_CTRL: begin
                rdata[CTRL_RUN]     = st_q.run;
                rdata[CTRL_ONESHOT] = st_q.oneshot;
                rdata[CTRL_WRAPONL] = st_q.wraponly;
            end
            REG_DIV:    rdata = st_q.div;
            REG_RELOAD: rdata = st_q.lim;
            REG_IEN:    rdata[0] = st_q.ien;
            REG_STAT:   rdata[0] = st_q.flag;
            REG_COUNT:  rdata = cnt;
            default:    rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{lim: '1, default: '0};
        else        st_q <= st_d;
    end

    // Hardware set of the flag on a wrap wins over any clear
    assert_wrap_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> st_q.flag);

    // Single-shot wrap stops the timer
    assert_oneshot_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && st_q.oneshot) |=> !st_q.run);

    // Writing one to the flag bit keeps it
    assert_stat_w1_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_STAT && wdata[0] && !ovf) |=> $stable(st_q.flag));

    // Forced update in wrap-only mode does not raise the flag
    assert_force_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (force_upd && st_q.wraponly && !ovf && !st_q.flag) |=> !st_q.flag);
endmodule

// File: rtl/basic_update_timer.sv
module basic_update_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              upd_o,
    output logic              irq_o
);
    logic             run;
    logic             force_upd;
    logic             tick;
    logic             ovf;
    logic             flag;
    logic             ien;
    logic [CNT_W-1:0] div_pre;
    logic [CNT_W-1:0] limit_pre;
    logic [CNT_W-1:0] cnt;

    assign upd_o = ovf || force_upd;
    assign irq_o = flag && ien;

    tmr_regs #(.W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .ovf       (ovf),
        .cnt       (cnt),
        .run       (run),
        .force_upd (force_upd),
        .div_pre   (div_pre),
        .limit_pre (limit_pre),
        .flag      (flag),
        .ien       (ien),
        .rdata     (rdata)
    );

    tmr_prescaler #(.W(CNT_W)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .force_upd (force_upd),
        .upd       (upd_o),
        .div_pre   (div_pre),
        .tick      (tick)
    );

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .force_upd (force_upd),
        .upd       (upd_o),
        .limit_pre (limit_pre),
        .cnt       (cnt),
        .ovf       (ovf)
    );
endmodule

// File: tb/basic_update_timer_tb_top.sv
module basic_update_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        upd_o;
    logic        irq_o;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    basic_update_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .upd_o(upd_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
        addr = a;
        @(negedge clk);
        chk(req, int'(rdata), exp);
        @(posedge clk); #2;
    endtask

    // Monitor: pop the expected cycle of each update pulse
    always @(negedge clk) begin
        if (rst_n && upd_o) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_fail++;
                $display("FAIL R2: actual unexpected update at cycle %0d expected none", cyc);
            end else begin
                chk("R2 update timing", cyc, exp_q.pop_front());
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int m;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd_chk("R1 ctrl", 3'd0, 0);
        rd_chk("R1 div", 3'd1, 0);
        rd_chk("R1 reload", 3'd2, 16'hFFFF);
        rd_chk("R1 force", 3'd3, 0);
        rd_chk("R1 ien", 3'd4, 0);
        rd_chk("R1 stat", 3'd5, 0);
        rd_chk("R1 count", 3'd6, 0);
        chk("R1 irq", int'(irq_o), 0);

        // R4 forced update, R6 flag set, R10 irq
        wr(3'd1, 16'd2);
        wr(3'd2, 16'd3);
        wr(3'd4, 16'd1);
        exp_q.push_back(cyc);
        wr(3'd3, 16'd1);
        rd_chk("R4 force reads 0", 3'd3, 0);
        rd_chk("R4 count zero", 3'd6, 0);
        rd_chk("R6 flag from force", 3'd5, 1);
        chk("R10 irq high", int'(irq_o), 1);

        // R8 write-zero clear
        wr(3'd5, 16'hFFFF);
        rd_chk("R8 write one keeps", 3'd5, 1);
        wr(3'd5, 16'hFFFE);
        rd_chk("R8 write zero clears", 3'd5, 0);
        chk("R10 irq low", int'(irq_o), 0);

        // R2 period (2+1)*(3+1)=12, R7 single shot
        m = cyc; exp_q.push_back(m + 12);
        wr(3'd0, 16'h3);
        idle(14);
        rd_chk("R7 run cleared", 3'd0, 2);
        rd_chk("R6 flag from wrap", 3'd5, 1);
        chk("R10 irq after wrap", int'(irq_o), 1);

        // R3 shadow: new divider applies only after the next update
        wr(3'd5, 16'hFFFE);
        wr(3'd1, 16'd0);
        m = cyc; exp_q.push_back(m + 12);
        wr(3'd0, 16'h3);
        idle(14);
        m = cyc; exp_q.push_back(m + 4);
        wr(3'd0, 16'h3);
        idle(6);
        rd_chk("R3 div holding value", 3'd1, 0);

        // R5 wrap-only: forced update leaves flag clear
        wr(3'd5, 16'hFFFE);
        wr(3'd0, 16'h4);
        wr(3'd2, 16'd1);
        exp_q.push_back(cyc);
        wr(3'd3, 16'd1);
        rd_chk("R5 flag unchanged", 3'd5, 0);
        chk("R5 irq low", int'(irq_o), 0);

        // R2 continuous, R9 clear collides with wrap at m+2
        m = cyc; exp_q.push_back(m + 2); exp_q.push_back(m + 4);
        wr(3'd0, 16'h5);
        idle(1);
        wr(3'd5, 16'hFFFE);
        idle(1);
        wr(3'd0, 16'h4);
        idle(4);
        rd_chk("R9 hardware set wins", 3'd5, 1);

        // R10 enable gating
        wr(3'd4, 16'd0);
        chk("R10 irq masked", int'(irq_o), 0);
        wr(3'd4, 16'd1);
        chk("R10 irq unmasked", int'(irq_o), 1);

        idle(4);
        chk("R2 all updates seen", exp_q.size(), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule